// File: doc/BRIEF.md
# Stereo DC-Offset Removal Filter with Offset Freeze

This block sits behind a stereo decimation filter and takes out any DC level in the audio. Each channel has its own running estimate of the DC offset. The estimate is kept in a fixed-point accumulator with 16 fractional bits. Every incoming sample moves the accumulator a binary fraction of the way toward the sample. The integer part of the estimate is subtracted from the sample. The difference is clipped to the 20-bit two's-complement range and sent out one clock later. This behaves as a first-order high-pass filter. In normal mode the step is 1/8192, which puts the corner at a fraction of a hertz at a 48 kHz word rate and gives a settling time of about a second.

The hold input does not bypass the filter. Instead it stops the accumulators, and the stored offset is still subtracted from every sample. System software can therefore let the filter settle on a silent input, raise hold, and keep that measured offset as a fixed correction.

A fast input changes the step to 1/64. Start-up calibration uses it to settle the estimate within a few hundred samples before the offset is frozen. Hold takes priority over fast.

Top module: `dcblock_hpf`

## Requirements
- R1: While rst_n is low at a clock edge, both outputs go to zero, both output strobes go low, and both offset estimates are cleared. As a result, the first sample after reset comes out unchanged.
- R2: A sample presented with its channel's valid strobe high appears on that channel's output exactly one clock later. The output strobe is high for that one cycle only. The output value is sat(x - D), where D = floor(A / 2^16) and A is the accumulator value held before the sample arrives.
- R3: With hold low and fast low, each valid sample updates the accumulator as A <= A + floor((x*2^16 - A) / 2^13).
- R4: With hold low and fast high, the update is A <= A + floor((x*2^16 - A) / 2^6). A constant input of 100000 is brought below 1000 at the output within 400 samples.
- R5: With hold high, valid samples leave the accumulator unchanged, and the frozen offset is still subtracted from each sample. Two samples taken during hold therefore give outputs whose difference equals the difference of the inputs.
- R6: A result above 524287 is output as 524287, and a result below -524288 is output as -524288.
- R7: The channels are independent. Index 0 is left and index 1 is right. A sample on one channel does not change the other channel's offset and does not raise the other channel's output strobe.
- R8: On cycles where a channel's valid strobe is low, that channel's output value holds and its output strobe stays low.
- R9: When hold and fast are both high, hold wins and the accumulators stay frozen.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| hold_i | input | 1 | Freezes both offset estimates; the frozen offsets are still subtracted |
| fast_i | input | 1 | Selects the fast-settling step used for calibration |
| l_smp_i | input | 20 | Left input sample, two's complement |
| l_vld_i | input | 1 | Left input sample valid |
| r_smp_i | input | 20 | Right input sample, two's complement |
| r_vld_i | input | 1 | Right input sample valid |
| l_smp_o | output | 20 | Left corrected sample |
| l_vld_o | output | 1 | Left corrected sample valid |
| r_smp_o | output | 20 | Right corrected sample |
| r_vld_o | output | 1 | Right corrected sample valid |

## Verification
The offset estimate can only be seen through the outputs. A wrong estimate shows as an output error on the next valid sample of that channel, one clock after that sample goes in. The bench compares every corrected sample with an exact model of the update rule, so a rounding or shift error that puts the accumulator off by one fractional LSB becomes visible once it reaches the integer part. A coarse error, such as the wrong step, a hold that leaks, or cross-channel coupling, appears within a few samples. A sticky error, such as a broken freeze or a broken clip, shows as an exact mismatch on the first sample that touches it.

// File: rtl/dcblk_pkg.sv
// Shared definitions for the DC-offset removal filter.
// Assumes two channels: index 0 is left, index 1 is right.
package dcblk_pkg;
    localparam int NUM_CH = 2;

    typedef enum logic {CH_LEFT = 1'b0, CH_RIGHT = 1'b1} chan_e;

    // Picks the accumulator step shift for the current mode.
    function automatic int pick_shift(input logic fast, input int k_slow, input int k_fast);
        return fast ? k_fast : k_slow;
    endfunction
endpackage

// File: rtl/dcblk_offset_track.sv
// Per-channel DC estimate: a leaky integrator A <= A + ((x<<F) - A) >>> K.
// Assumes K_SLOW and K_FAST are smaller than SMP_W + FRAC_W. The integer
// part is floor(A / 2^F), and one guard bit is kept above it.
module dcblk_offset_track #(
    parameter int SMP_W  = 20,
    parameter int FRAC_W = 16,
    parameter int K_SLOW = 13,
    parameter int K_FAST = 6
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               smp_vld,
    input  logic [SMP_W-1:0]   smp,
    input  logic               hold,
    input  logic               fast,
    output logic [SMP_W:0]     ofs
);
    import dcblk_pkg::*;

    localparam int ACC_W = SMP_W + FRAC_W;
    localparam int ERR_W = ACC_W + 1;

    logic        [ACC_W-1:0] x_scaled;
    logic        [ERR_W-1:0] acc_q;
    logic signed [ERR_W-1:0] err;
    logic signed [ERR_W-1:0] step;
    logic        [ERR_W-1:0] acc_nxt;
    int                      shamt;

    // Scale the sample, form the error, and take the shifted step.
    always_comb begin
        x_scaled = {smp, {FRAC_W{1'b0}}};
        err      = {x_scaled[ACC_W-1], x_scaled} - acc_q;
        shamt    = pick_shift(fast, K_SLOW, K_FAST);
        step     = err >>> shamt;
        acc_nxt  = acc_q + step;
    end

    // Accumulator register: cleared on reset, advanced only on unheld samples.
    always_ff @(posedge clk) begin
        if (!rst_n)
            acc_q <= '0;
        else if (smp_vld && !hold)
            acc_q <= acc_nxt;
    end

    assign ofs = acc_q[ERR_W-1:FRAC_W];
endmodule

// File: rtl/dcblk_sat_sub.sv
// Combinational x - ofs, clipped to the SMP_W-bit two's-complement range.
// Assumes ofs carries one extra sign bit compared with x.
module dcblk_sat_sub #(
    parameter int SMP_W = 20
) (
    input  logic [SMP_W-1:0] smp,
    input  logic [SMP_W:0]   ofs,
    output logic [SMP_W-1:0] res
);
    localparam logic [SMP_W-1:0] POS_MAX = {1'b0, {(SMP_W-1){1'b1}}};
    localparam logic [SMP_W-1:0] NEG_MIN = {1'b1, {(SMP_W-1){1'b0}}};

    logic [SMP_W+1:0] diff;
    logic [2:0]       top;

    // Subtract at full width, then clip if the top three bits disagree.
    always_comb begin
        diff = {{2{smp[SMP_W-1]}}, smp} - {ofs[SMP_W], ofs};
        top  = diff[SMP_W+1:SMP_W-1];
        if (top == 3'b000 || top == 3'b111)
            res = diff[SMP_W-1:0];
        else
            res = diff[SMP_W+1] ? NEG_MIN : POS_MAX;
    end
endmodule

// File: rtl/dcblk_chan.sv
// One channel: offset tracker, clipped subtractor, and output register.
// Assumes samples arrive no faster than one per clock.
module dcblk_chan #(
    parameter int SMP_W  = 20,
    parameter int FRAC_W = 16,
    parameter int K_SLOW = 13,
    parameter int K_FAST = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             hold,
    input  logic             fast,
    input  logic [SMP_W-1:0] smp_i,
    input  logic             vld_i,
    output logic [SMP_W-1:0] smp_o,
    output logic             vld_o,
    output logic [SMP_W:0]   ofs_o
);
    logic [SMP_W-1:0] corr;

    dcblk_offset_track #(
        .SMP_W(SMP_W), .FRAC_W(FRAC_W), .K_SLOW(K_SLOW), .K_FAST(K_FAST)
    ) u_track (
        .clk(clk), .rst_n(rst_n), .smp_vld(vld_i), .smp(smp_i),
        .hold(hold), .fast(fast), .ofs(ofs_o)
    );

    dcblk_sat_sub #(.SMP_W(SMP_W)) u_sub (
        .smp(smp_i), .ofs(ofs_o), .res(corr)
    );

    // Output register: load the corrected sample, strobe valid for one cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            smp_o <= '0;
            vld_o <= 1'b0;
        end else begin
            vld_o <= vld_i;
            if (vld_i)
                smp_o <= corr;
        end
    end
endmodule

// File: rtl/dcblock_hpf.sv
// Stereo DC-offset removal high-pass filter with an offset freeze.
// Assumes both channels share the same mode inputs and that each channel
// strobes valid on its own.
module dcblock_hpf #(
    parameter int SMP_W  = 20,
    parameter int FRAC_W = 16,
    parameter int K_SLOW = 13,
    parameter int K_FAST = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             hold_i,
    input  logic             fast_i,
    input  logic [SMP_W-1:0] l_smp_i,
    input  logic             l_vld_i,
    input  logic [SMP_W-1:0] r_smp_i,
    input  logic             r_vld_i,
    output logic [SMP_W-1:0] l_smp_o,
    output logic             l_vld_o,
    output logic [SMP_W-1:0] r_smp_o,
    output logic             r_vld_o
);
    import dcblk_pkg::*;

    logic [SMP_W-1:0] smp_in  [NUM_CH];
    logic             vld_in  [NUM_CH];
    logic [SMP_W-1:0] smp_out [NUM_CH];
    logic             vld_out [NUM_CH];
    logic [SMP_W:0]   ofs     [NUM_CH];
    logic [SMP_W:0]   ofs_l;
    logic [SMP_W:0]   ofs_r;

    assign smp_in[CH_LEFT]  = l_smp_i;
    assign vld_in[CH_LEFT]  = l_vld_i;
    assign smp_in[CH_RIGHT] = r_smp_i;
    assign vld_in[CH_RIGHT] = r_vld_i;

    for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_ch
        dcblk_chan #(
            .SMP_W(SMP_W), .FRAC_W(FRAC_W), .K_SLOW(K_SLOW), .K_FAST(K_FAST)
        ) u_chan (
            .clk(clk), .rst_n(rst_n), .hold(hold_i), .fast(fast_i),
            .smp_i(smp_in[ch]), .vld_i(vld_in[ch]),
            .smp_o(smp_out[ch]), .vld_o(vld_out[ch]), .ofs_o(ofs[ch])
        );
    end

    assign l_smp_o = smp_out[CH_LEFT];
    assign l_vld_o = vld_out[CH_LEFT];
    assign r_smp_o = smp_out[CH_RIGHT];
    assign r_vld_o = vld_out[CH_RIGHT];
    assign ofs_l   = ofs[CH_LEFT];
    assign ofs_r   = ofs[CH_RIGHT];
endmodule

// File: rtl/dcblock_hpf_chk.sv
// Temporal checks on the filter, attached to the top module by bind.
module dcblock_hpf_chk #(
    parameter int SMP_W = 20
) (
    input logic             clk,
    input logic             rst_n,
    input logic             hold_i,
    input logic             l_vld_i,
    input logic             r_vld_i,
    input logic             l_vld_o,
    input logic             r_vld_o,
    input logic [SMP_W-1:0] l_smp_o,
    input logic [SMP_W-1:0] r_smp_o,
    input logic [SMP_W:0]   ofs_l,
    input logic [SMP_W:0]   ofs_r
);
    p_lat_left_r2: assert property (@(posedge clk) disable iff (!rst_n)
        l_vld_i |=> l_vld_o);
    p_lat_right_r2: assert property (@(posedge clk) disable iff (!rst_n)
        r_vld_i |=> r_vld_o);
    p_freeze_left_r5: assert property (@(posedge clk) disable iff (!rst_n)
        hold_i |=> $stable(ofs_l));
    p_freeze_right_r5: assert property (@(posedge clk) disable iff (!rst_n)
        hold_i |=> $stable(ofs_r));
    p_idle_left_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !l_vld_i |=> ($stable(ofs_l) && !l_vld_o));
    p_idle_right_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !r_vld_i |=> ($stable(ofs_r) && !r_vld_o));
    p_hold_out_left_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !l_vld_i |=> $stable(l_smp_o));
    p_hold_out_right_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !r_vld_i |=> $stable(r_smp_o));
endmodule

bind dcblock_hpf dcblock_hpf_chk #(.SMP_W(SMP_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .hold_i(hold_i),
    .l_vld_i(l_vld_i), .r_vld_i(r_vld_i),
    .l_vld_o(l_vld_o), .r_vld_o(r_vld_o),
    .l_smp_o(l_smp_o), .r_smp_o(r_smp_o),
    .ofs_l(ofs_l), .ofs_r(ofs_r)
);

// File: tb/dcblock_hpf_bench.sv
`timescale 1ns/1ps
module dcblock_hpf_bench;
    localparam int SMP_W = 20;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             hold_i = 1'b0;
    logic             fast_i = 1'b0;
    logic [SMP_W-1:0] l_smp_i = '0;
    logic             l_vld_i = 1'b0;
    logic [SMP_W-1:0] r_smp_i = '0;
    logic             r_vld_i = 1'b0;
    logic [SMP_W-1:0] l_smp_o;
    logic             l_vld_o;
    logic [SMP_W-1:0] r_smp_o;
    logic             r_vld_o;

    int     n_chk  = 0;
    int     n_bad  = 0;
    bit     done   = 0;
    longint acc_m [2];
    longint last_l, last_r;

    always #2 clk = ~clk;

    dcblock_hpf u_dcblock_hpf (
        .clk(clk), .rst_n(rst_n), .hold_i(hold_i), .fast_i(fast_i),
        .l_smp_i(l_smp_i), .l_vld_i(l_vld_i), .r_smp_i(r_smp_i), .r_vld_i(r_vld_i),
        .l_smp_o(l_smp_o), .l_vld_o(l_vld_o), .r_smp_o(r_smp_o), .r_vld_o(r_vld_o)
    );

    function automatic longint sat20(input longint v);
        if (v > 524287)  return 524287;
        if (v < -524288) return -524288;
        return v;
    endfunction

    function automatic longint s20(input logic [SMP_W-1:0] v);
        return longint'($signed(v));
    endfunction

    task automatic check(input string req, input longint act, input longint exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0; l_vld_i = 1'b0; r_vld_i = 1'b0;
        hold_i = 1'b0; fast_i = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        acc_m[0] = 0; acc_m[1] = 0;
    endtask

    // Model of the update rule from R3/R4, with hold from R5/R9.
    task automatic model_step(input int ch, input longint x);
        longint err;
        int k;
        if (hold_i) return;
        k = fast_i ? 6 : 13;
        err = x * 65536 - acc_m[ch];
        acc_m[ch] = acc_m[ch] + (err >>> k);
    endtask

    // Send one sample on each selected channel and check the result a cycle later.
    task automatic send(input longint xl, input longint xr, input bit vl, input bit vr,
                        input string req);
        longint el, er;
        el = sat20(xl - (acc_m[0] >>> 16));
        er = sat20(xr - (acc_m[1] >>> 16));
        @(negedge clk);
        l_smp_i = 20'(xl); r_smp_i = 20'(xr); l_vld_i = vl; r_vld_i = vr;
        if (vl) model_step(0, xl);
        if (vr) model_step(1, xr);
        @(negedge clk);
        l_vld_i = 1'b0; r_vld_i = 1'b0;
        check({req, " left strobe"}, longint'(l_vld_o), longint'(vl));
        check({req, " right strobe"}, longint'(r_vld_o), longint'(vr));
        if (vl) begin check({req, " left"}, s20(l_smp_o), el); last_l = s20(l_smp_o); end
        if (vr) begin check({req, " right"}, s20(r_smp_o), er); last_r = s20(r_smp_o); end
    endtask

    task automatic t_reset_state();
        do_reset();
        @(negedge clk);
        check("R1 left out", s20(l_smp_o), 0);
        check("R1 right out", s20(r_smp_o), 0);
        check("R1 left strobe", longint'(l_vld_o), 0);
        check("R1 right strobe", longint'(r_vld_o), 0);
        send(1234, -777, 1, 1, "R1");
        check("R1 pass-through left", last_l, 1234);
        check("R1 pass-through right", last_r, -777);
    endtask

    task automatic t_track_slow();
        do_reset();
        for (int i = 0; i < 300; i++) send(40000, -25000, 1, 1, "R3");
        check("R3 left decayed", longint'(last_l < 40000), 1);
        check("R3 right decayed", longint'(last_r > -25000), 1);
        send(-3000, 5000, 1, 1, "R2");
    endtask

    task automatic t_fast_then_freeze();
        longint a, b;
        do_reset();
        fast_i = 1'b1;
        for (int i = 0; i < 400; i++) send(100000, 100000, 1, 1, "R4");
        check("R4 settled", longint'(last_l < 1000 && last_l > -1000), 1);
        fast_i = 1'b0; hold_i = 1'b1;
        send(100000, 0, 1, 1, "R5");
        a = last_l;
        send(50000, 0, 1, 1, "R5");
        b = last_l;
        check("R5 offset still subtracted", a - b, 50000);
        check("R5 right frozen offset", last_r, 0 - (acc_m[1] >>> 16));
        fast_i = 1'b1;
        send(7000, 7000, 1, 1, "R9");
        a = last_l;
        send(7000, 7000, 1, 1, "R9");
        check("R9 hold beats fast", last_l, a);
        hold_i = 1'b0; fast_i = 1'b0;
    endtask

    task automatic t_saturate();
        do_reset();
        fast_i = 1'b1;
        for (int i = 0; i < 600; i++) send(-500000, 500000, 1, 1, "R4");
        fast_i = 1'b0; hold_i = 1'b1;
        send(500000, -500000, 1, 1, "R6");
        check("R6 positive clip", last_l, 524287);
        check("R6 negative clip", last_r, -524288);
        hold_i = 1'b0;
    endtask

    task automatic t_independent();
        do_reset();
        fast_i = 1'b1;
        for (int i = 0; i < 300; i++) send(200000, 0, 1, 0, "R7");
        fast_i = 1'b0;
        send(0, 777, 0, 1, "R7");
        check("R7 right offset untouched", last_r, 777);
    endtask

    task automatic t_idle_hold();
        longint l0, r0;
        do_reset();
        send(-4321, 9876, 1, 1, "R8");
        l0 = s20(l_smp_o); r0 = s20(r_smp_o);
        @(negedge clk); l_smp_i = 20'(11111); r_smp_i = 20'(-2222);
        for (int i = 0; i < 5; i++) begin
            @(negedge clk);
            check("R8 left held", s20(l_smp_o), l0);
            check("R8 right held", s20(r_smp_o), r0);
            check("R8 strobe low", longint'(l_vld_o | r_vld_o), 0);
        end
        send(100, 100, 1, 1, "R8");
    endtask

    initial begin
        t_reset_state();
        t_track_slow();
        t_fast_then_freeze();
        t_saturate();
        t_independent();
        t_idle_hold();
        if (!done) begin
            done = 1;
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            done = 1;
            n_chk++; n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end
endmodule